// File: doc/BRIEF.md
# Two-level priority interrupt controller

This block gathers interrupt events from five core sources (three external pins, a timer and a port-change detector) and from 29 peripheral sources held in five register banks of 7, 8, 8, 3 and 3 bits. Each source keeps a latched flag, an enable and a route bit. Flag AND enable qualifies a source. In two-level mode the route bit sends a qualified source to the urgent or the normal group. The block then raises one request line toward the CPU core and presents the matching vector address: 0x0008 for the urgent level and 0x0018 for the normal level.

A run-time mode bit picks between two-level operation and a single-level compatibility mode, and this changes what the two global gate bits mean. The first external pin is wired into the urgent group and cannot be moved. The port-change source only latches a flag when a pin with its own change enable toggles. A wake output tells the power controller that some qualified source is pending, whatever the global gates are. When the core acknowledges, the block closes the global gate of the level being serviced. Software clears flags by writing the flag registers.

Top module: `intc_two_level`

## Requirements
- R1: The clock edge that sees a source's event pulse sets that source's flag, whatever its enable, its route bit or the global gates. The flag is visible through the register port after that edge.
- R2: `irq_vector` is 0x0008 while `irq_hi` is high, 0x0018 while `irq_lo` is high, and 0x0000 when neither is high.
- R3: In two-level mode (control bit 0 = 1), a qualified source whose route bit is 1 raises `irq_hi` only while gate A (control bit 1) is 1. A qualified source whose route bit is 0 raises `irq_lo` only while gate A and gate B (control bit 2) are both 1.
- R4: In single-level mode (control bit 0 = 0), `irq_lo` stays low and every request uses `irq_hi` and 0x0008. A qualified core source needs gate A. A qualified peripheral source needs gate A and gate B.
- R5: The external pin 0 source (core bit 0) is always routed urgent. Bit 0 of the core route register reads 1 after reset and after any write.
- R6: The port-change flag (core bit 2) is set only when a `pin_chg` pulse arrives on a pin whose bit in the pin enable register (address 0x04) is 1.
- R7: `wake` is high exactly when some source has flag AND enable set, independent of mode and gates.
- R8: When urgent and normal requests are both pending, `irq_hi` is high, `irq_lo` is low and the vector is 0x0008.
- R9: A `cpu_ack` pulse clears gate A if `irq_hi` is high, otherwise clears gate B if `irq_lo` is high, otherwise it does nothing. Flags are left unchanged.
- R10: Writing a flag register replaces its flags with the written data, except that an event arriving in the same cycle still sets its flag.
- R11: Register map (read by `reg_addr` with no delay): 0x00 control {gate B, gate A, mode} in bits 2:0; 0x01/0x02/0x03 core flag/enable/route, with bits ext0, timer, port-change, ext1, ext2 from bit 0 upward; 0x04 pin enables; 0x08+3k, 0x09+3k and 0x0A+3k bank k flag/enable/route. Unused bits and addresses read 0. After reset everything reads 0 except core route bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext0_evt | input | 1 | External pin 0 event pulse (fixed urgent) |
| tmr_evt | input | 1 | Timer event pulse |
| ext1_evt | input | 1 | External pin 1 event pulse |
| ext2_evt | input | 1 | External pin 2 event pulse |
| pin_chg | input | NUM_PINS | Per-pin change pulses for the port-change source |
| per_evt | input | 29 | Peripheral event pulses, bank 0 in the low bits |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| cpu_ack | input | 1 | Core acknowledge pulse |
| irq_hi | output | 1 | Urgent-level request |
| irq_lo | output | 1 | Normal-level request |
| irq_vector | output | 16 | Vector address of the presented request |
| wake | output | 1 | Wake-up from idle or sleep |

## Verification
The assertions assume events and acknowledges are one-cycle samples taken at the clock edge. They also assume that a same-cycle write to the control register and an acknowledge resolve in that order, with the acknowledge clearing its gate last. The random stimulus keeps event density low (about one in 32 per bit), so flags build up slowly and software-style writes clear them again. Acknowledges arrive whether or not a request is pending, which covers the no-op case. Directed sequences move the mode and gate bits through the combinations that matter and hit the same-cycle write-versus-event case.

// File: rtl/intc_pkg.sv
// Shared constants, bank geometry and types for the two-level interrupt controller.
// Assumes bank widths are fixed per product; all derived widths are computed here.
package intc_pkg;
    localparam int NUM_BANKS = 5;
    localparam int REG_W     = 8;
    localparam int ADDR_W    = 5;
    localparam int CORE_W    = 5;
    localparam int VEC_W     = 16;

    // core source bit positions (decoded by software and by the fixed-route mask)
    localparam int CORE_EXT0 = 0;
    localparam int CORE_TMR  = 1;
    localparam int CORE_PCHG = 2;
    localparam int CORE_EXT1 = 3;
    localparam int CORE_EXT2 = 4;

    // register addresses
    localparam int A_CTRL  = 0;
    localparam int A_CFLG  = 1;
    localparam int A_CEN   = 2;
    localparam int A_CPRI  = 3;
    localparam int A_PINEN = 4;
    localparam int A_BANK0 = 8;

    // control register bit positions
    localparam int CTRL_MODE = 0;
    localparam int CTRL_GA   = 1;
    localparam int CTRL_GB   = 2;
    localparam int CTRL_W    = 3;

    localparam logic [VEC_W-1:0] VEC_HI   = 16'h0008;
    localparam logic [VEC_W-1:0] VEC_LO   = 16'h0018;
    localparam logic [VEC_W-1:0] VEC_NONE = 16'h0000;

    // width of peripheral bank b
    function automatic int bank_width(input int b);
        case (b)
            0:       return 7;
            1, 2:    return 8;
            default: return 3;
        endcase
    endfunction

    // bit offset of peripheral bank b inside the flat event vector
    function automatic int bank_offset(input int b);
        int s;
        s = 0;
        for (int i = 0; i < b; i++) s += bank_width(i);
        return s;
    endfunction

    localparam int PER_TOTAL = bank_offset(NUM_BANKS);

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_HI   = 2'd1,
        LVL_LO   = 2'd2
    } lvl_e;
endpackage

// File: rtl/intc_src_bank.sv
// One bank of interrupt sources: latched flags, enables and route bits.
// Reports whether any qualified source routes urgent or normal.
// Assumes events are one-cycle samples; a same-cycle event beats a software write.
// Bits set in FIXED_HI are always routed urgent and their route bit is not writable.
module intc_src_bank #(
    parameter int           W        = 8,
    parameter logic [W-1:0] FIXED_HI = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         wr_flag,
    input  logic         wr_en,
    input  logic         wr_pri,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flag,
    output logic [W-1:0] en,
    output logic [W-1:0] pri,
    output logic         any_hi,
    output logic         any_lo
);
    logic [W-1:0] act;

    // flag latch: events always set, software write replaces
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= '0;
        else if (wr_flag) flag <= wdata | evt;
        else              flag <= flag | evt;
    end

    // enable register
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= '0;
        else if (wr_en) en <= wdata;
    end

    // route register with fixed-urgent bits forced
    always_ff @(posedge clk) begin
        if (!rst_n)      pri <= FIXED_HI;
        else if (wr_pri) pri <= wdata | FIXED_HI;
    end

    // qualification and group summary
    always_comb begin
        act    = flag & en;
        any_hi = |(act & pri);
        any_lo = |(act & ~pri);
    end

    p_flag_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((flag & $past(evt)) == $past(evt)));

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_flag && !(|evt)) |=> $stable(flag));

    p_fixed_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pri |=> ((pri & FIXED_HI) == FIXED_HI));
endmodule

// File: rtl/intc_gate.sv
// Applies mode and global gates to the group summaries.
// Two-level: gate A passes urgent, gate A and B pass normal.
// Single-level: gate A passes core sources, gate A and B pass peripherals; all urgent.
module intc_gate (
    input  logic mode,
    input  logic g_a,
    input  logic g_b,
    input  logic core_hi,
    input  logic core_lo,
    input  logic per_hi,
    input  logic per_lo,
    output logic req_hi,
    output logic req_lo
);
    // gating per mode
    always_comb begin
        if (mode) begin
            req_hi = g_a & (core_hi | per_hi);
            req_lo = g_a & g_b & (core_lo | per_lo);
        end else begin
            req_hi = g_a & (core_hi | core_lo | (g_b & (per_hi | per_lo)));
            req_lo = 1'b0;
        end
    end
endmodule

// File: rtl/intc_vector.sv
// Picks the presented level (urgent wins) and drives request lines and vector.
// Assumes the request inputs are already gated.
module intc_vector import intc_pkg::*; (
    input  logic             req_hi,
    input  logic             req_lo,
    output logic             irq_hi,
    output logic             irq_lo,
    output logic [VEC_W-1:0] vector
);
    lvl_e lvl;

    // level arbitration
    always_comb begin
        if (req_hi)      lvl = LVL_HI;
        else if (req_lo) lvl = LVL_LO;
        else             lvl = LVL_NONE;
    end

    // level to outputs
    always_comb begin
        irq_hi = (lvl == LVL_HI);
        irq_lo = (lvl == LVL_LO);
        case (lvl)
            LVL_HI:  vector = VEC_HI;
            LVL_LO:  vector = VEC_LO;
            default: vector = VEC_NONE;
        endcase
    end
endmodule

// File: rtl/intc_ctrl_reg.sv
// Control register: mode and two global gates, with acknowledge-driven gate clear.
// Assumes a same-cycle write lands first and the acknowledge clear overrides it.
module intc_ctrl_reg import intc_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              ack,
    input  logic              irq_hi,
    input  logic              irq_lo,
    output logic              mode,
    output logic              g_a,
    output logic              g_b
);
    logic [CTRL_W-1:0] ctrl_q, ctrl_d;

    // next-state: write, then acknowledge closes the serviced gate
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) ctrl_d = wdata;
        if (ack) begin
            if (irq_hi)      ctrl_d[CTRL_GA] = 1'b0;
            else if (irq_lo) ctrl_d[CTRL_GB] = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign mode = ctrl_q[CTRL_MODE];
    assign g_a  = ctrl_q[CTRL_GA];
    assign g_b  = ctrl_q[CTRL_GB];

    p_ack_closes_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_hi) |=> !g_a);

    p_ack_closes_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_hi && irq_lo) |=> !g_b);
endmodule

// File: rtl/intc_two_level.sv
// Top of the two-level priority interrupt controller.
// Holds the core bank, the peripheral banks, the pin-change enables and the
// register read mux, and joins the gate, vector and control pieces.
// Assumes all inputs are synchronous to clk.
module intc_two_level import intc_pkg::*; #(
    parameter int NUM_PINS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ext0_evt,
    input  logic                 tmr_evt,
    input  logic                 ext1_evt,
    input  logic                 ext2_evt,
    input  logic [NUM_PINS-1:0]  pin_chg,
    input  logic [PER_TOTAL-1:0] per_evt,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 cpu_ack,
    output logic                 irq_hi,
    output logic                 irq_lo,
    output logic [VEC_W-1:0]     irq_vector,
    output logic                 wake
);
    localparam logic [CORE_W-1:0] CORE_FIXED = CORE_W'(1) << CORE_EXT0;

    logic [NUM_PINS-1:0] pin_en;
    logic                pchg_hit;
    logic [CORE_W-1:0]   core_evt, core_flag, core_en, core_pri;
    logic                core_hi, core_lo;
    logic [NUM_BANKS-1:0] bank_hi, bank_lo;
    logic [REG_W-1:0]    rd_flag [NUM_BANKS];
    logic [REG_W-1:0]    rd_en   [NUM_BANKS];
    logic [REG_W-1:0]    rd_pri  [NUM_BANKS];
    logic                per_hi, per_lo;
    logic                mode, g_a, g_b;
    logic                req_hi, req_lo;

    // pin change enable register
    always_ff @(posedge clk) begin
        if (!rst_n)                                           pin_en <= '0;
        else if (reg_wr && reg_addr == ADDR_W'(A_PINEN))      pin_en <= reg_wdata[NUM_PINS-1:0];
    end

    // port-change qualification and core event vector
    always_comb begin
        pchg_hit            = |(pin_chg & pin_en);
        core_evt            = '0;
        core_evt[CORE_EXT0] = ext0_evt;
        core_evt[CORE_TMR]  = tmr_evt;
        core_evt[CORE_PCHG] = pchg_hit;
        core_evt[CORE_EXT1] = ext1_evt;
        core_evt[CORE_EXT2] = ext2_evt;
    end

    intc_src_bank #(.W(CORE_W), .FIXED_HI(CORE_FIXED)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (core_evt),
        .wr_flag (reg_wr && reg_addr == ADDR_W'(A_CFLG)),
        .wr_en   (reg_wr && reg_addr == ADDR_W'(A_CEN)),
        .wr_pri  (reg_wr && reg_addr == ADDR_W'(A_CPRI)),
        .wdata   (reg_wdata[CORE_W-1:0]),
        .flag    (core_flag),
        .en      (core_en),
        .pri     (core_pri),
        .any_hi  (core_hi),
        .any_lo  (core_lo)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int BW   = bank_width(b);
        localparam int BO   = bank_offset(b);
        localparam int BASE = A_BANK0 + 3 * b;
        logic [BW-1:0] f, e, p;

        intc_src_bank #(.W(BW), .FIXED_HI('0)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (per_evt[BO +: BW]),
            .wr_flag (reg_wr && reg_addr == ADDR_W'(BASE)),
            .wr_en   (reg_wr && reg_addr == ADDR_W'(BASE + 1)),
            .wr_pri  (reg_wr && reg_addr == ADDR_W'(BASE + 2)),
            .wdata   (reg_wdata[BW-1:0]),
            .flag    (f),
            .en      (e),
            .pri     (p),
            .any_hi  (bank_hi[b]),
            .any_lo  (bank_lo[b])
        );

        assign rd_flag[b] = REG_W'(f);
        assign rd_en[b]   = REG_W'(e);
        assign rd_pri[b]  = REG_W'(p);
    end

    // peripheral group summary and wake
    always_comb begin
        per_hi = |bank_hi;
        per_lo = |bank_lo;
        wake   = core_hi | core_lo | per_hi | per_lo;
    end

    intc_gate u_gate (
        .mode    (mode),
        .g_a     (g_a),
        .g_b     (g_b),
        .core_hi (core_hi),
        .core_lo (core_lo),
        .per_hi  (per_hi),
        .per_lo  (per_lo),
        .req_hi  (req_hi),
        .req_lo  (req_lo)
    );

    intc_vector u_vec (
        .req_hi (req_hi),
        .req_lo (req_lo),
        .irq_hi (irq_hi),
        .irq_lo (irq_lo),
        .vector (irq_vector)
    );

    intc_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr && reg_addr == ADDR_W'(A_CTRL)),
        .wdata  (reg_wdata[CTRL_W-1:0]),
        .ack    (cpu_ack),
        .irq_hi (irq_hi),
        .irq_lo (irq_lo),
        .mode   (mode),
        .g_a    (g_a),
        .g_b    (g_b)
    );

    // register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(A_CTRL):  reg_rdata = REG_W'({g_b, g_a, mode});
            ADDR_W'(A_CFLG):  reg_rdata = REG_W'(core_flag);
            ADDR_W'(A_CEN):   reg_rdata = REG_W'(core_en);
            ADDR_W'(A_CPRI):  reg_rdata = REG_W'(core_pri);
            ADDR_W'(A_PINEN): reg_rdata = REG_W'(pin_en);
            default:          reg_rdata = '0;
        endcase
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (reg_addr == ADDR_W'(A_BANK0 + 3 * b))     reg_rdata = rd_flag[b];
            if (reg_addr == ADDR_W'(A_BANK0 + 3 * b + 1)) reg_rdata = rd_en[b];
            if (reg_addr == ADDR_W'(A_BANK0 + 3 * b + 2)) reg_rdata = rd_pri[b];
        end
    end

    p_vec_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> (irq_vector == VEC_HI));

    p_vec_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> (irq_vector == VEC_LO));

    p_one_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_hi, irq_lo}));

    p_single_no_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> !irq_lo);

    p_req_needs_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi || irq_lo) |-> g_a);

    p_req_implies_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi || irq_lo) |-> wake);

    p_pchg_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|(pin_chg & pin_en)) && !(reg_wr && reg_addr == ADDR_W'(A_CFLG)))
        |=> (core_flag[CORE_PCHG] == $past(core_flag[CORE_PCHG])));
endmodule

// File: tb/intc_two_level_bench.sv
// Self-checking bench: a register-level model computed from the requirements,
// random stimulus with a fixed seed, plus directed corner sequences.
module intc_two_level_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP   = 4;
    localparam int PT   = 29;
    localparam int SEED = 20240611;

    bit          clk;
    logic        rst_n;
    logic        ext0_evt, tmr_evt, ext1_evt, ext2_evt;
    logic [NP-1:0] pin_chg;
    logic [PT-1:0] per_evt;
    logic [4:0]  reg_addr;
    logic        reg_wr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        cpu_ack;
    logic        irq_hi, irq_lo, wake;
    logic [15:0] irq_vector;

    int errors = 0;
    int checks = 0;

    // model state
    logic [2:0]    m_ctrl;
    logic [4:0]    m_cf, m_ce, m_cp;
    logic [NP-1:0] m_pin;
    logic [PT-1:0] m_pf, m_pe, m_pp;

    intc_two_level #(.NUM_PINS(NP)) u_intc_two_level (
        .clk(clk), .rst_n(rst_n),
        .ext0_evt(ext0_evt), .tmr_evt(tmr_evt), .ext1_evt(ext1_evt), .ext2_evt(ext2_evt),
        .pin_chg(pin_chg), .per_evt(per_evt),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_ack(cpu_ack), .irq_hi(irq_hi), .irq_lo(irq_lo),
        .irq_vector(irq_vector), .wake(wake)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int bw(input int b);
        if (b == 0) return 7;
        if (b == 1 || b == 2) return 8;
        return 3;
    endfunction

    function automatic int bo(input int b);
        int s = 0;
        for (int i = 0; i < b; i++) s += bw(i);
        return s;
    endfunction

    // {hi, lo} expected from R3, R4, R5, R8
    function automatic logic [1:0] exp_req();
        logic [4:0] ca, cpf;
        logic [PT-1:0] pa;
        logic chi, clo, phi, plo, hi, lo;
        cpf = m_cp | 5'b00001;
        ca  = m_cf & m_ce;
        pa  = m_pf & m_pe;
        chi = |(ca & cpf);  clo = |(ca & ~cpf);
        phi = |(pa & m_pp); plo = |(pa & ~m_pp);
        if (m_ctrl[0]) begin
            hi = m_ctrl[1] & (chi | phi);
            lo = m_ctrl[1] & m_ctrl[2] & (clo | plo) & ~hi;
        end else begin
            hi = m_ctrl[1] & (chi | clo | (m_ctrl[2] & (phi | plo)));
            lo = 1'b0;
        end
        return {hi, lo};
    endfunction

    function automatic logic exp_wake();
        return (|(m_cf & m_ce)) | (|(m_pf & m_pe));
    endfunction

    function automatic logic [7:0] exp_read(input logic [4:0] a);
        logic [7:0] r = 8'h00;
        int k, b, s;
        case (a)
            5'd0: r = {5'b0, m_ctrl};
            5'd1: r = {3'b0, m_cf};
            5'd2: r = {3'b0, m_ce};
            5'd3: r = {3'b0, m_cp | 5'b00001};
            5'd4: r = {4'b0, m_pin};
            default: begin
                if (a >= 5'd8 && a <= 5'd22) begin
                    k = int'(a) - 8; b = k / 3; s = k % 3;
                    for (int i = 0; i < bw(b); i++) begin
                        if (s == 0) r[i] = m_pf[bo(b) + i];
                        else if (s == 1) r[i] = m_pe[bo(b) + i];
                        else r[i] = m_pp[bo(b) + i];
                    end
                end
            end
        endcase
        return r;
    endfunction

    task automatic model_reset();
        m_ctrl = '0; m_cf = '0; m_ce = '0; m_cp = 5'b00001; m_pin = '0;
        m_pf = '0; m_pe = '0; m_pp = '0;
    endtask

    // advance model by one edge using the inputs held across it
    task automatic model_edge();
        logic [1:0] rq;
        logic [4:0] cevt;
        int k, b, s;
        rq   = exp_req();
        cevt = {ext2_evt, ext1_evt, |(pin_chg & m_pin), tmr_evt, ext0_evt};
        if (reg_wr) begin
            case (reg_addr)
                5'd0: m_ctrl = reg_wdata[2:0];
                5'd1: m_cf   = reg_wdata[4:0];
                5'd2: m_ce   = reg_wdata[4:0];
                5'd3: m_cp   = reg_wdata[4:0] | 5'b00001;
                5'd4: m_pin  = reg_wdata[NP-1:0];
                default: begin
                    if (reg_addr >= 5'd8 && reg_addr <= 5'd22) begin
                        k = int'(reg_addr) - 8; b = k / 3; s = k % 3;
                        for (int i = 0; i < bw(b); i++) begin
                            if (s == 0) m_pf[bo(b) + i] = reg_wdata[i];
                            else if (s == 1) m_pe[bo(b) + i] = reg_wdata[i];
                            else m_pp[bo(b) + i] = reg_wdata[i];
                        end
                    end
                end
            endcase
        end
        m_cf = m_cf | cevt;
        m_pf = m_pf | per_evt;
        if (cpu_ack) begin
            if (rq[1])      m_ctrl[1] = 1'b0;
            else if (rq[0]) m_ctrl[2] = 1'b0;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [1:0] rq;
        logic [15:0] v;
        rq = exp_req();
        v  = rq[1] ? 16'h0008 : (rq[0] ? 16'h0018 : 16'h0000);
        chk("R3/R4/R8 irq_hi", 32'(irq_hi), 32'(rq[1]));
        chk("R3/R4/R8 irq_lo", 32'(irq_lo), 32'(rq[0]));
        chk("R2 vector", 32'(irq_vector), 32'(v));
        chk("R7 wake", 32'(wake), 32'(exp_wake()));
        chk("R1/R10/R11 readback", 32'(reg_rdata), 32'(exp_read(reg_addr)));
    endtask

    task automatic clear_in();
        ext0_evt = 0; tmr_evt = 0; ext1_evt = 0; ext2_evt = 0;
        pin_chg = '0; per_evt = '0; reg_wr = 0; reg_wdata = '0; cpu_ack = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        check_all();
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); clear_in();
        reg_addr = a; reg_wr = 1; reg_wdata = d;
        tick();
    endtask

    task automatic peek(input logic [4:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); clear_in();
        reg_addr = a; #1;
        chk(tag, 32'(reg_rdata), 32'(e));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int r;
        r = $urandom(SEED);
        clear_in(); reg_addr = '0; rst_n = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk("R11 reset irq_hi", 32'(irq_hi), 0);
        chk("R11 reset vector", 32'(irq_vector), 0);
        rst_n = 1;
        peek(5'd0, 8'h00, "R11 reset ctrl");
        peek(5'd3, 8'h01, "R5 R11 reset core route");
        peek(5'd8, 8'h00, "R11 reset bank0 flag");

        // R1: flag sets with enables and gates off
        @(negedge clk); clear_in(); per_evt[0] = 1; tick();
        peek(5'd8, 8'h01, "R1 flag without enable");
        chk("R7 wake needs enable", 32'(wake), 0);

        // R7: enable alone wakes, no request with gates closed
        wr(5'd9, 8'h01);
        chk("R7 wake with gates closed", 32'(wake), 1);
        chk("R3 no request gates closed", 32'({irq_hi, irq_lo}), 0);

        // R3: normal group needs gate B too
        wr(5'd0, 8'h03);
        chk("R3 normal blocked by gate B", 32'(irq_lo), 0);
        wr(5'd0, 8'h07);
        chk("R3 normal passes", 32'(irq_lo), 1);
        chk("R2 normal vector", 32'(irq_vector), 32'h18);

        // R8/R5: ext0 urgent preempts
        wr(5'd2, 8'h01);
        @(negedge clk); clear_in(); ext0_evt = 1; tick();
        chk("R8 urgent wins hi", 32'(irq_hi), 1);
        chk("R8 urgent wins lo", 32'(irq_lo), 0);
        chk("R8 vector", 32'(irq_vector), 32'h8);

        // R9: ack closes gate A, flags kept
        @(negedge clk); clear_in(); cpu_ack = 1; tick();
        chk("R9 ack drops request", 32'({irq_hi, irq_lo}), 0);
        peek(5'd0, 8'h05, "R9 gate A closed");
        peek(5'd1, 8'h01, "R9 flags kept");

        // R9: ack of normal level closes gate B
        wr(5'd0, 8'h07);
        wr(5'd1, 8'h00);
        chk("R9 normal pending", 32'(irq_lo), 1);
        @(negedge clk); clear_in(); cpu_ack = 1; tick();
        peek(5'd0, 8'h03, "R9 gate B closed");

        // R5: fixed route bit
        wr(5'd3, 8'h00);
        peek(5'd3, 8'h01, "R5 route bit0 sticks");

        // R6: pin change masking
        wr(5'd2, 8'h04);
        @(negedge clk); clear_in(); pin_chg = 4'b0001; tick();
        peek(5'd1, 8'h00, "R6 masked pin ignored");
        wr(5'd4, 8'h02);
        @(negedge clk); clear_in(); pin_chg = 4'b0010; tick();
        peek(5'd1, 8'h04, "R6 enabled pin sets flag");

        // R4: single-level mode
        wr(5'd0, 8'h02);
        chk("R4 core uses urgent", 32'(irq_hi), 1);
        chk("R4 vector", 32'(irq_vector), 32'h8);
        chk("R4 no normal", 32'(irq_lo), 0);
        wr(5'd1, 8'h00);
        chk("R4 peripheral needs gate B", 32'(irq_hi), 0);
        wr(5'd0, 8'h06);
        chk("R4 peripheral passes", 32'(irq_hi), 1);

        // R10: same-cycle event beats clear
        @(negedge clk); clear_in();
        reg_addr = 5'd8; reg_wr = 1; reg_wdata = 8'h00; per_evt[1] = 1;
        tick();
        peek(5'd8, 8'h02, "R10 event beats write");

        // random phase
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk); clear_in();
            per_evt  = PT'($urandom & $urandom & $urandom & $urandom & $urandom);
            ext0_evt = ($urandom % 40) == 0;
            tmr_evt  = ($urandom % 30) == 0;
            ext1_evt = ($urandom % 30) == 0;
            ext2_evt = ($urandom % 30) == 0;
            pin_chg  = NP'($urandom & $urandom & $urandom);
            reg_addr = 5'($urandom);
            if (($urandom % 4) == 0) begin
                reg_wr = 1;
                reg_wdata = 8'($urandom);
            end
            cpu_ack = ($urandom % 8) == 0;
            tick();
        end
        finish_run();
    end
endmodule